// File: doc/BRIEF.md
# I2C Slave Byte Controller with Status Codes

This block is the slave side of an I2C interface that hands every byte to a host through a small register file. The host owns four registers: a control register, an own-address register, a data register and a read-only status register. The block watches SCL and SDA through a synchronizer and detects START and STOP conditions. It shifts in address and data bytes, or shifts data out. It answers each acknowledge clock with ACK or NACK, depending on the acknowledge-enable bit.

Each time the block reaches a defined protocol state, it loads a 5-bit status code and sets an interrupt flag. While the flag is set, the block holds SCL low, so the master waits. The host reads the status, handles the data register and then clears the flag to let the transfer go on. The block covers the addressed receiver, the addressed transmitter, the general-call receiver and the not-addressed mode.

Register index (`host_idx`):
- 0 is control. Bit 0 enables general call, bit 1 is the acknowledge enable (AA), bit 2 is the interrupt flag (SI) and bit 3 is the stop request (STO).
- 1 is the own address, held in bits 7:1.
- 2 is the data register.
- 3 is the status register.

Top module: `i2c_slave_byte_ctrl`

## Requirements
- R1: Status (index 3) holds the code in bits 7:3, and bits 2:0 always read 0. Reset gives F8h, and F8h is never present while the interrupt flag is set by a state entry.
- R2: Only the hardware sets the flag. Writing 0 to control bit 2 clears it, and writing 1 to that bit has no effect. The flag drives `irq`.
- R3: While the flag is set and SCL has been seen low, `scl_drive_low` is 1. A flag set while SCL is high does not pull SCL low.
- R4: With AA=1, a matching address byte gets an ACK. The status becomes 60h for write (R/W bit 0) or A8h for read (R/W bit 1).
- R5: An address byte of 00h gets an ACK with status 70h only when general call is enabled and AA=1. Otherwise it gets a NACK and no flag.
- R6: A data byte received while addressed is written to the data register. With AA=1 it gets an ACK and status 80h (own address) or 90h (general call). With AA=0 it gets a NACK, status 88h or 98h, and the block becomes not addressed.
- R7: As transmitter, the block loads the data register when the flag is cleared and sends it MSB first. A master ACK gives B8h, or C8h if AA was 0 when the byte was loaded. A master NACK gives C0h. After C8h or C0h the block stops driving SDA.
- R8: With AA=0, an address byte gets no ACK and raises no flag.
- R9: Setting AA while an address byte is partly shifted in still lets that byte match when it completes.
- R10: Writing 1 to control bit 3 puts the block in not-addressed mode at once. SDA is released, bit 3 reads back 0, and later data bytes get no ACK and no flag until the next START.
- R11: A STOP or repeated START seen while addressed as a receiver sets the flag with status A0h. A STOP seen in not-addressed mode sets nothing.
- R12: The status code is updated on the same clock edge as the flag is set. It keeps its value for one clock after the flag is cleared and then reads F8h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_idx | input | 2 | Register index |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for `host_idx` |
| irq | output | 1 | Interrupt flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (open drain) |
| sda_drive_low | output | 1 | Pull SDA low (open drain) |

## Verification
Some rules are checked by the assertions on every cycle:
- the flag falls only on a host clear, and a flag set by a state entry never carries F8h;
- the status stays unchanged on the edge where the flag is cleared;
- SCL stretching starts only with SCL low and only while the flag is set;
- an ACK on SDA is driven only when AA allowed it;
- SDA is quiet in not-addressed mode.

Other behaviour is shown only by the bench's bus scenarios:
- the actual status sequence and the data values moved in each direction;
- the outcome of setting AA halfway through an address;
- the internal stop request;
- the last-byte C8h path that releases the bus.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   localparam int BYTE_W = 8;
   localparam int CODE_W = 5;

   typedef enum logic [3:0] {
      PH_IDLE, PH_ADDR, PH_IGNORE, PH_AACK, PH_RX, PH_RACK,
      PH_TXWAIT, PH_TX, PH_TACK
   } phase_t;

   // status codes, upper five bits of the visible byte
   localparam logic [CODE_W-1:0] ST_OWN_W   = 5'h0C; // 60h
   localparam logic [CODE_W-1:0] ST_GC      = 5'h0E; // 70h
   localparam logic [CODE_W-1:0] ST_DAT_ACK = 5'h10; // 80h
   localparam logic [CODE_W-1:0] ST_DAT_NAK = 5'h11; // 88h
   localparam logic [CODE_W-1:0] ST_GCD_ACK = 5'h12; // 90h
   localparam logic [CODE_W-1:0] ST_GCD_NAK = 5'h13; // 98h
   localparam logic [CODE_W-1:0] ST_ENDED   = 5'h14; // A0h
   localparam logic [CODE_W-1:0] ST_OWN_R   = 5'h15; // A8h
   localparam logic [CODE_W-1:0] ST_TX_ACK  = 5'h17; // B8h
   localparam logic [CODE_W-1:0] ST_TX_NAK  = 5'h18; // C0h
   localparam logic [CODE_W-1:0] ST_TX_LAST = 5'h19; // C8h
   localparam logic [CODE_W-1:0] ST_NONE    = 5'h1F; // F8h
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [1:0] line_raw;
   logic [1:0] line_s;
   logic [1:0] line_p;

   assign line_raw = {sda_in, scl_in};

   for (genvar gi = 0; gi < 2; gi++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain      <= '1;
            line_p[gi] <= 1'b1;
         end else begin
            chain      <= {chain[STAGES-2:0], line_raw[gi]};
            line_p[gi] <= chain[STAGES-1];
         end
      end
      assign line_s[gi] = chain[STAGES-1];
   end

   assign scl_s     = line_s[0];
   assign sda_s     = line_s[1];
   assign scl_rise  = line_s[0] & ~line_p[0];
   assign scl_fall  = ~line_s[0] & line_p[0];
   assign start_det = line_s[0] & line_p[0] & line_p[1] & ~line_s[1];
   assign stop_det  = line_s[0] & line_p[0] & ~line_p[1] & line_s[1];
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
   import i2cs_pkg::*;
#(
   parameter logic [BYTE_W-2:0] GC_ADDR = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_s,
   input  logic                    sda_s,
   input  logic                    scl_rise,
   input  logic                    scl_fall,
   input  logic                    start_det,
   input  logic                    stop_det,
   input  logic [BYTE_W-2:0]       own_addr,
   input  logic                    aa,
   input  logic                    aa_now,
   input  logic                    gc_en,
   input  logic [BYTE_W-1:0]       tx_byte,
   input  logic                    si,
   input  logic                    si_clear,
   input  logic                    sto_pulse,
   output logic                    set_evt,
   output logic [CODE_W-1:0]       set_code,
   output logic                    rx_we,
   output logic [BYTE_W-1:0]       rx_byte,
   output logic                    sda_low,
   output logic                    scl_low
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   phase_t              phase_q, phase_n;
   logic [CNT_W-1:0]    cnt_q, cnt_n;
   logic [BYTE_W-1:0]   sh_q, sh_n;
   logic                sda_q, sda_n;
   logic                gc_q, gc_n;
   logic                last_q, last_n;
   logic                ack_q, ack_n;
   logic [CODE_W-1:0]   pend_q, pend_n;
   logic                stretch_q;
   logic                si_nxt;
   logic                own_hit, gc_hit;

   assign own_hit = aa && (sh_q[BYTE_W-1:1] == own_addr);
   assign gc_hit  = aa && gc_en && (sh_q[BYTE_W-1:1] == GC_ADDR) && !sh_q[0];

   always_comb begin
      phase_n  = phase_q;
      cnt_n    = cnt_q;
      sh_n     = sh_q;
      sda_n    = sda_q;
      gc_n     = gc_q;
      last_n   = last_q;
      ack_n    = ack_q;
      pend_n   = pend_q;
      set_evt  = 1'b0;
      set_code = ST_NONE;
      rx_we    = 1'b0;
      if (sto_pulse) begin
         phase_n = PH_IDLE;
         sda_n   = 1'b0;
      end else if (start_det || stop_det) begin
         if (phase_q == PH_RX) begin
            set_evt  = 1'b1;
            set_code = ST_ENDED;
         end
         phase_n = start_det ? PH_ADDR : PH_IDLE;
         cnt_n   = '0;
         sda_n   = 1'b0;
      end else begin
         unique case (phase_q)
            PH_ADDR: begin
               if (scl_rise) begin
                  sh_n  = {sh_q[BYTE_W-2:0], sda_s};
                  cnt_n = cnt_q + 1'b1;
               end else if (scl_fall && cnt_q == CNT_FULL) begin
                  if (own_hit) begin
                     sda_n   = 1'b1;
                     gc_n    = 1'b0;
                     pend_n  = sh_q[0] ? ST_OWN_R : ST_OWN_W;
                     phase_n = PH_AACK;
                  end else if (gc_hit) begin
                     sda_n   = 1'b1;
                     gc_n    = 1'b1;
                     pend_n  = ST_GC;
                     phase_n = PH_AACK;
                  end else begin
                     sda_n   = 1'b0;
                     phase_n = PH_IGNORE;
                  end
               end
            end
            PH_AACK: begin
               if (scl_fall) begin
                  set_evt  = 1'b1;
                  set_code = pend_q;
                  sda_n    = 1'b0;
                  cnt_n    = '0;
                  phase_n  = (pend_q == ST_OWN_R) ? PH_TXWAIT : PH_RX;
               end
            end
            PH_RX: begin
               if (scl_rise) begin
                  sh_n  = {sh_q[BYTE_W-2:0], sda_s};
                  cnt_n = cnt_q + 1'b1;
               end else if (scl_fall && cnt_q == CNT_FULL) begin
                  rx_we   = 1'b1;
                  sda_n   = aa;
                  ack_n   = aa;
                  pend_n  = gc_q ? (aa ? ST_GCD_ACK : ST_GCD_NAK)
                                 : (aa ? ST_DAT_ACK : ST_DAT_NAK);
                  phase_n = PH_RACK;
               end
            end
            PH_RACK: begin
               if (scl_fall) begin
                  set_evt  = 1'b1;
                  set_code = pend_q;
                  sda_n    = 1'b0;
                  cnt_n    = '0;
                  phase_n  = ack_q ? PH_RX : PH_IDLE;
               end
            end
            PH_TXWAIT: begin
               if (si_clear) begin
                  sh_n    = tx_byte;
                  last_n  = !aa_now;
                  sda_n   = !tx_byte[BYTE_W-1];
                  cnt_n   = '0;
                  phase_n = PH_TX;
               end
            end
            PH_TX: begin
               if (scl_fall) begin
                  cnt_n = cnt_q + 1'b1;
                  if (cnt_q == CNT_LAST) begin
                     sda_n   = 1'b0;
                     phase_n = PH_TACK;
                  end else begin
                     sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
                     sda_n = !sh_q[BYTE_W-2];
                  end
               end
            end
            PH_TACK: begin
               if (scl_rise) begin
                  ack_n = !sda_s;
               end else if (scl_fall) begin
                  set_evt  = 1'b1;
                  set_code = !ack_q ? ST_TX_NAK : (last_q ? ST_TX_LAST : ST_TX_ACK);
                  phase_n  = (ack_q && !last_q) ? PH_TXWAIT : PH_IDLE;
               end
            end
            default: ;
         endcase
      end
   end

   assign si_nxt = set_evt | (si & ~si_clear);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         sh_q      <= '0;
         sda_q     <= 1'b0;
         gc_q      <= 1'b0;
         last_q    <= 1'b0;
         ack_q     <= 1'b0;
         pend_q    <= ST_NONE;
         stretch_q <= 1'b0;
      end else begin
         phase_q   <= phase_n;
         cnt_q     <= cnt_n;
         sh_q      <= sh_n;
         sda_q     <= sda_n;
         gc_q      <= gc_n;
         last_q    <= last_n;
         ack_q     <= ack_n;
         pend_q    <= pend_n;
         stretch_q <= si_nxt & (stretch_q | scl_fall);
      end
   end

   assign rx_byte = sh_q;
   assign sda_low = sda_q;
   assign scl_low = stretch_q;

   p_stretch_from_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_low) |-> !scl_s);
   p_stretch_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      scl_low |-> si);
   p_addr_ack_needs_aa_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_low) && phase_q == PH_AACK) |-> $past(aa));
   p_quiet_unaddressed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE || phase_q == PH_IGNORE) |-> !sda_low);
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
   import i2cs_pkg::*;
#(
   parameter logic [BYTE_W-2:0] OWN_RESET = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_we,
   input  logic [1:0]         host_idx,
   input  logic [BYTE_W-1:0]  host_wdata,
   output logic [BYTE_W-1:0]  host_rdata,
   input  logic               set_evt,
   input  logic [CODE_W-1:0]  set_code,
   input  logic               rx_we,
   input  logic [BYTE_W-1:0]  rx_byte,
   output logic [BYTE_W-2:0]  own_addr,
   output logic               aa,
   output logic               aa_now,
   output logic               gc_en,
   output logic [BYTE_W-1:0]  tx_byte,
   output logic               si,
   output logic               si_clear,
   output logic               sto_pulse
);
   localparam int LOW_W = BYTE_W - CODE_W;

   logic              ctl_wr;
   logic [CODE_W-1:0] status_q;
   logic              clr_d;
   logic [BYTE_W-1:0] data_q;

   assign ctl_wr    = host_we && host_idx == 2'd0;
   assign si_clear  = ctl_wr && !host_wdata[2] && si;
   assign sto_pulse = ctl_wr && host_wdata[3];
   assign aa_now    = ctl_wr ? host_wdata[1] : aa;
   assign tx_byte   = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aa       <= 1'b0;
         gc_en    <= 1'b0;
         si       <= 1'b0;
         own_addr <= OWN_RESET;
         data_q   <= '0;
         status_q <= ST_NONE;
         clr_d    <= 1'b0;
      end else begin
         if (ctl_wr) begin
            aa    <= host_wdata[1];
            gc_en <= host_wdata[0];
         end
         if (set_evt)       si <= 1'b1;
         else if (si_clear) si <= 1'b0;
         if (host_we && host_idx == 2'd1) own_addr <= host_wdata[BYTE_W-1:1];
         if (rx_we)                            data_q <= rx_byte;
         else if (host_we && host_idx == 2'd2) data_q <= host_wdata;
         clr_d <= si_clear && !set_evt;
         if (set_evt)    status_q <= set_code;
         else if (clr_d) status_q <= ST_NONE;
      end
   end

   always_comb begin
      unique case (host_idx)
         2'd0:    host_rdata = {{(BYTE_W-3){1'b0}}, si, aa, gc_en};
         2'd1:    host_rdata = {own_addr, 1'b0};
         2'd2:    host_rdata = data_q;
         default: host_rdata = {status_q, {LOW_W{1'b0}}};
      endcase
   end

   p_flag_set_not_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(si) |-> status_q != ST_NONE);
   p_flag_host_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(si) |-> $past(ctl_wr && !host_wdata[2]));
   p_status_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(si) |-> $stable(status_q));
endmodule

// File: rtl/i2c_slave_byte_ctrl.sv
module i2c_slave_byte_ctrl
   import i2cs_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter logic [BYTE_W-2:0] OWN_RESET  = '0,
   parameter logic [BYTE_W-2:0] GC_ADDR    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [1:0]        host_idx,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   output logic              irq,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_drive_low,
   output logic              sda_drive_low
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic set_evt, rx_we, aa, aa_now, gc_en, si, si_clear, sto_pulse;
   logic [CODE_W-1:0] set_code;
   logic [BYTE_W-1:0] rx_byte, tx_byte;
   logic [BYTE_W-2:0] own_addr;

   i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2cs_engine #(.GC_ADDR(GC_ADDR)) u_engine (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .own_addr(own_addr), .aa(aa), .aa_now(aa_now),
      .gc_en(gc_en), .tx_byte(tx_byte), .si(si), .si_clear(si_clear),
      .sto_pulse(sto_pulse), .set_evt(set_evt), .set_code(set_code),
      .rx_we(rx_we), .rx_byte(rx_byte), .sda_low(sda_drive_low),
      .scl_low(scl_drive_low));

   i2cs_regs #(.OWN_RESET(OWN_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idx(host_idx),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .set_evt(set_evt),
      .set_code(set_code), .rx_we(rx_we), .rx_byte(rx_byte),
      .own_addr(own_addr), .aa(aa), .aa_now(aa_now), .gc_en(gc_en),
      .tx_byte(tx_byte), .si(si), .si_clear(si_clear), .sto_pulse(sto_pulse));

   assign irq = si;
endmodule

// File: tb/i2c_slave_byte_ctrl_test.sv
module i2c_slave_byte_ctrl_test;
   logic clk = 0;
   logic rst_n = 0;
   logic host_we = 0;
   logic [1:0] host_idx = 0;
   logic [7:0] host_wdata = 0;
   logic [7:0] host_rdata;
   logic irq, scl_drive_low, sda_drive_low;
   logic scl_m = 1, sda_m = 1;
   wire  scl_line = scl_m & ~scl_drive_low;
   wire  sda_line = sda_m & ~sda_drive_low;
   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   i2c_slave_byte_ctrl uut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idx(host_idx),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
      .scl_in(scl_line), .sda_in(sda_line),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low));

   // {address byte, aa, gc_en, expect ack, expected status}
   localparam logic [18:0] VEC [7] = '{
      {8'hB4, 1'b1, 1'b0, 1'b1, 8'h60},
      {8'hB5, 1'b1, 1'b0, 1'b1, 8'hA8},
      {8'hB4, 1'b0, 1'b0, 1'b0, 8'hF8},
      {8'h00, 1'b1, 1'b1, 1'b1, 8'h70},
      {8'h00, 1'b1, 1'b0, 1'b0, 8'hF8},
      {8'hB6, 1'b1, 1'b1, 1'b0, 8'hF8},
      {8'h00, 1'b0, 1'b1, 1'b0, 8'hF8}};

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] i, input logic [7:0] v);
      @(negedge clk);
      host_idx = i; host_wdata = v; host_we = 1;
      @(negedge clk);
      host_we = 0;
   endtask

   task automatic rd(input logic [1:0] i, output logic [7:0] v);
      host_idx = i;
      #1;
      v = host_rdata;
   endtask

   task automatic m_start;
      sda_m = 1; scl_m = 1; ticks(6);
      sda_m = 0; ticks(6);
      scl_m = 0; ticks(6);
   endtask

   task automatic m_stop;
      sda_m = 0; ticks(4);
      scl_m = 1; wait (scl_line); ticks(6);
      sda_m = 1; ticks(8);
   endtask

   task automatic m_bit(input logic b);
      sda_m = b; ticks(4);
      scl_m = 1; wait (scl_line); ticks(8);
      scl_m = 0; ticks(6);
   endtask

   task automatic m_rbit(output logic b);
      sda_m = 1; ticks(4);
      scl_m = 1; wait (scl_line); ticks(4);
      b = sda_line; ticks(4);
      scl_m = 0; ticks(6);
   endtask

   task automatic m_wbyte(input logic [7:0] v, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) m_bit(v[i]);
      m_rbit(a);
      ack = !a;
   endtask

   task automatic m_rbyte(output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         m_rbit(b);
         v[i] = b;
      end
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic ack;
      ticks(3);
      rst_n = 1;
      ticks(2);
      rd(3, v); chk("R1 reset status", v, 8'hF8);
      rd(0, v); chk("R2 reset control", v, 8'h00);
      chk("R3 reset drives", {6'd0, scl_drive_low, sda_drive_low}, 8'h00);
      wr(1, 8'hB4);
      rd(1, v); chk("R4 own address readback", v, 8'hB4);

      // address recognition table
      foreach (VEC[k]) begin
         wr(0, {6'd0, VEC[k][10], VEC[k][9]});
         m_start();
         m_wbyte(VEC[k][18:11], ack);
         chk("R4 R5 R8 address ack", {7'd0, ack}, {7'd0, VEC[k][8]});
         chk("R2 R8 flag", {7'd0, irq}, {7'd0, VEC[k][8]});
         rd(3, v); chk("R1 R4 R5 status", v, VEC[k][7:0]);
         if (VEC[k][8]) wr(0, 8'h08);
         ticks(4);
         m_stop();
      end

      // receiver flow
      wr(0, 8'h02);
      m_start();
      m_wbyte(8'hB4, ack);
      chk("R3 stretch active", {7'd0, scl_drive_low}, 8'h01);
      ticks(40);
      chk("R3 stretch holds", {7'd0, scl_line}, 8'h00);
      wr(0, 8'h02);
      rd(3, v); chk("R12 status held after clear", v, 8'h60);
      chk("R2 flag cleared", {7'd0, irq}, 8'h00);
      ticks(1);
      rd(3, v); chk("R12 status idle after clear", v, 8'hF8);
      chk("R3 stretch released", {7'd0, scl_drive_low}, 8'h00);
      m_wbyte(8'h3C, ack);
      chk("R6 data ack", {7'd0, ack}, 8'h01);
      rd(3, v); chk("R6 status 80", v, 8'h80);
      rd(2, v); chk("R6 data stored", v, 8'h3C);
      wr(0, 8'h00);
      m_wbyte(8'hC3, ack);
      chk("R6 data nack", {7'd0, ack}, 8'h00);
      rd(3, v); chk("R6 status 88", v, 8'h88);
      rd(2, v); chk("R6 data stored nack", v, 8'hC3);
      wr(0, 8'h00);
      m_stop();
      chk("R11 no flag when unaddressed", {7'd0, irq}, 8'h00);

      // STOP while addressed
      wr(0, 8'h02);
      m_start();
      m_wbyte(8'hB4, ack);
      wr(0, 8'h02);
      m_stop();
      chk("R11 flag on stop", {7'd0, irq}, 8'h01);
      rd(3, v); chk("R11 status A0", v, 8'hA0);
      chk("R3 high scl not pulled", {7'd0, scl_drive_low}, 8'h00);
      wr(0, 8'h02);

      // AA set partway through an address
      wr(0, 8'h00);
      m_start();
      for (int i = 7; i >= 4; i--) m_bit(v[0] | 1'b0 ? 1'b0 : 8'hB4 >> i);
      wr(0, 8'h02);
      for (int i = 3; i >= 0; i--) m_bit(8'hB4 >> i);
      m_rbit(v[0]);
      chk("R9 late AA matches", {7'd0, !v[0]}, 8'h01);
      rd(3, v); chk("R9 status", v, 8'h60);
      wr(0, 8'h0A);
      ticks(4);
      m_stop();

      // general call data
      wr(0, 8'h03);
      m_start();
      m_wbyte(8'h00, ack);
      wr(0, 8'h03);
      m_wbyte(8'h11, ack);
      chk("R5 R6 gc data ack", {7'd0, ack}, 8'h01);
      rd(3, v); chk("R6 status 90", v, 8'h90);
      wr(0, 8'h0B);
      ticks(4);
      m_stop();

      // transmitter with last byte
      wr(0, 8'h02);
      m_start();
      m_wbyte(8'hB5, ack);
      wr(2, 8'hA5);
      wr(0, 8'h02);
      m_rbyte(v);
      chk("R7 first byte sent", v, 8'hA5);
      m_bit(1'b0);
      rd(3, v); chk("R7 status B8", v, 8'hB8);
      wr(2, 8'h96);
      wr(0, 8'h00);
      m_rbyte(v);
      chk("R7 last byte sent", v, 8'h96);
      m_bit(1'b0);
      rd(3, v); chk("R7 status C8", v, 8'hC8);
      wr(0, 8'h02);
      m_rbit(v[0]);
      chk("R7 sda released after C8", {7'd0, v[0]}, 8'h01);
      m_stop();

      // transmitter with master NACK
      m_start();
      m_wbyte(8'hB5, ack);
      wr(2, 8'h0F);
      wr(0, 8'h02);
      m_rbyte(v);
      chk("R7 byte before nack", v, 8'h0F);
      m_bit(1'b1);
      rd(3, v); chk("R7 status C0", v, 8'hC0);
      wr(0, 8'h02);
      chk("R7 sda released after C0", {7'd0, sda_drive_low}, 8'h00);
      m_stop();

      // internal stop request
      m_start();
      m_wbyte(8'hB4, ack);
      wr(0, 8'h0A);
      rd(0, v); chk("R10 stop bit reads zero", v, 8'h02);
      chk("R10 sda released", {7'd0, sda_drive_low}, 8'h00);
      m_wbyte(8'h55, ack);
      chk("R10 data ignored", {7'd0, ack}, 8'h00);
      chk("R10 no flag", {7'd0, irq}, 8'h00);
      m_stop();

      // writing 1 to the flag does nothing
      wr(0, 8'h06);
      rd(0, v); chk("R2 flag not host settable", v, 8'h02);
      rd(3, v); chk("R1 low bits zero", {5'd0, v[2:0]}, 8'h00);

      summary();
      $finish;
   end
endmodule